// File: doc/BRIEF.md
# Memory-Mapped Interrupt Controller

This block collects up to 32 interrupt request lines and presents them to a processor as one interrupt wire. Each request line is fixed at build time as edge-sensitive or level-sensitive by a kind mask parameter. A 1 in the mask makes the line edge-sensitive and a 0 makes it level-sensitive. Requests are latched into a status register whatever the mask holds. The enable mask decides which latched requests count as pending. A two-bit master enable gates the final output.

Software drives the controller through a plain 32-bit register port. The port has a three-bit word index, a write strobe, a read strobe and separate write and read data buses. Read data is combinational, so it is valid in the same cycle as the read strobe. Besides a direct write, the enable mask has two write-one alias words: one sets bits and one clears them. Neither needs a read-modify-write. An acknowledge word clears latched requests bit by bit. A vector word returns the number of the lowest pending line as a plain integer.

There is no sequencer. Each status bit is a two-state cell with the states CLEAR and HELD. The transition SET goes from CLEAR to HELD, on a rising edge for an edge-sensitive line or on a high sample for a level-sensitive line. The transition ACK goes from HELD to CLEAR when a 1 is written to that bit of the acknowledge word and no SET occurs in the same cycle.

Top module: `intc_top`

## Requirements
- R1: After reset, the status, enable and master registers read 0, `irq_out` is low, and the vector word reads 32'hFFFF_FFFF.
- R2: `irq_out` is high exactly when at least one pending bit is set and both master bits are 1. Master bit 0 is the overall enable and bit 1 is the hardware output enable. A master value of 1 or 2 keeps the output low.
- R3: Writing word 2 (byte 0x08) replaces the enable mask. Writing word 4 (byte 0x10) ORs the data into the mask. Writing word 5 (byte 0x14) clears the mask bits where the data is 1. Data bits that are 0 leave the mask unchanged in both alias writes.
- R4: Writing word 3 (byte 0x0C) clears each status bit whose data bit is 1, and writing all ones clears every latched request. If a new request arrives in the same cycle as its acknowledge, the status bit stays set.
- R5: An edge-sensitive line (kind bit 1) sets its status bit on a rising edge, found by comparing the input with its value one clock earlier. After an acknowledge the bit stays clear while the line remains high, until the next rising edge.
- R6: A level-sensitive line (kind bit 0) sets its status bit in every cycle that it is high, so an acknowledge does not clear the bit while the line is still asserted.
- R7: Word 0 (byte 0x00) reads the status register. Word 1 (byte 0x04) reads status AND enable. Word 7 (byte 0x1C) reads the master value in bits 1:0, with zeros above.
- R8: Word 6 (byte 0x18) reads the index of the lowest-numbered pending line as an unsigned integer, or 32'hFFFF_FFFF when nothing is pending.
- R9: Words 3, 4 and 5 read as 0. Writes to words 0, 1 and 6 change nothing. `rdata` is 0 whenever `rd_en` is low.
- R10: Enable bits at or above `N_IN` cannot be set by any write and always read 0. Kind-mask bits at or above `N_IN` have no effect.
- R11: A request is latched into status even while its enable bit is 0. Enabling the line later makes the request pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Word index of the register (byte offset / 4) |
| wr_en | input | 1 | Write strobe, one write per cycle it is high |
| rd_en | input | 1 | Read strobe, gates `rdata` |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from `reg_addr` |
| irq_in | input | N_IN | Interrupt request lines |
| irq_out | output | 1 | Interrupt to the processor |

## Verification
The collision that matters is an acknowledge write arriving in the same clock as a fresh request on the same line. The request can be a rising edge on an edge-sensitive line or a still-high level-sensitive line. The bench forces this case on edge line 3 and level line 5, and the random phase meets it again many times. After each case the bench judges the status word against the rule that the request wins. A second overlap arises when alias writes to the enable mask change `irq_out` in the cycle after they are written. The behavioural model compares every such cycle.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int DATA_W = 32;
    localparam int SEL_W  = 3;

    // Word index of each register; the byte offset is four times the index.
    typedef enum logic [SEL_W-1:0] {
        SEL_STATUS = 3'd0,
        SEL_PEND   = 3'd1,
        SEL_ENABLE = 3'd2,
        SEL_ACK    = 3'd3,
        SEL_SETEN  = 3'd4,
        SEL_CLREN  = 3'd5,
        SEL_VECTOR = 3'd6,
        SEL_MASTER = 3'd7
    } reg_sel_e;

endpackage

// File: rtl/intc_src_cell.sv
// One request line: CLEAR/HELD status cell with an edge or level front end.
module intc_src_cell #(
    parameter bit IS_EDGE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic ack,
    output logic flag
);
    logic hit;

    generate
        if (IS_EDGE) begin : g_edge
            logic req_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) req_q <= 1'b0;
                else        req_q <= req;
            end
            assign hit = req & ~req_q;
        end else begin : g_level
            assign hit = req;
        end
    endgenerate

    // SET wins over ACK in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag <= 1'b0;
        else        flag <= hit | (flag & ~ack);
    end
endmodule

// File: rtl/intc_mask_regs.sv
// Enable mask with direct, set and clear writes, plus the two-bit master enable.
module intc_mask_regs
    import intc_pkg::*;
#(
    parameter int N_IN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] enable,
    output logic [1:0]        master
);
    localparam logic [DATA_W:0]   ONES_WIDE = (33'd1 << N_IN) - 33'd1;
    localparam logic [DATA_W-1:0] VALID     = ONES_WIDE[DATA_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable <= '0;
            master <= 2'b00;
        end else if (wr_en) begin
            unique case (sel)
                SEL_ENABLE: enable <= wdata & VALID;
                SEL_SETEN:  enable <= (enable | wdata) & VALID;
                SEL_CLREN:  enable <= enable & ~wdata;
                SEL_MASTER: master <= wdata[1:0];
                default:    ;
            endcase
        end
    end
endmodule

// File: rtl/intc_vec_enc.sv
// Lowest-index encoder; all ones when no input is set.
module intc_vec_enc #(
    parameter int N_IN  = 8,
    parameter int OUT_W = 32
) (
    input  logic [N_IN-1:0]  pend,
    output logic [OUT_W-1:0] vec
);
    always_comb begin
        vec = '1;
        for (int i = N_IN - 1; i >= 0; i--) begin
            if (pend[i]) vec = OUT_W'(i);
        end
    end
endmodule

// File: rtl/intc_top.sv
module intc_top
    import intc_pkg::*;
#(
    parameter int          N_IN      = 8,
    parameter logic [31:0] KIND_MASK = 32'h0000_FF0F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  reg_addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [N_IN-1:0]   irq_in,
    output logic              irq_out
);
    localparam logic [N_IN-1:0] KIND_USED = KIND_MASK[N_IN-1:0];

    reg_sel_e          sel;
    logic [N_IN-1:0]   ack_vec;
    logic [N_IN-1:0]   status;
    logic [N_IN-1:0]   pending;
    logic [DATA_W-1:0] enable;
    logic [1:0]        master;
    logic [DATA_W-1:0] vec_idx;

    assign sel     = reg_sel_e'(reg_addr);
    assign ack_vec = (wr_en && sel == SEL_ACK) ? wdata[N_IN-1:0] : '0;

    generate
        for (genvar g = 0; g < N_IN; g++) begin : g_src
            intc_src_cell #(.IS_EDGE(KIND_USED[g])) u_cell (
                .clk  (clk),
                .rst_n(rst_n),
                .req  (irq_in[g]),
                .ack  (ack_vec[g]),
                .flag (status[g])
            );
        end
    endgenerate

    intc_mask_regs #(.N_IN(N_IN)) u_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .sel   (sel),
        .wdata (wdata),
        .enable(enable),
        .master(master)
    );

    assign pending = status & enable[N_IN-1:0];

    intc_vec_enc #(.N_IN(N_IN), .OUT_W(DATA_W)) u_vec (
        .pend(pending),
        .vec (vec_idx)
    );

    assign irq_out = (|pending) & master[0] & master[1];

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (sel)
                SEL_STATUS: rdata = DATA_W'(status);
                SEL_PEND:   rdata = DATA_W'(pending);
                SEL_ENABLE: rdata = enable;
                SEL_ACK:    rdata = '0;
                SEL_SETEN:  rdata = '0;
                SEL_CLREN:  rdata = '0;
                SEL_VECTOR: rdata = vec_idx;
                SEL_MASTER: rdata = {{(DATA_W-2){1'b0}}, master};
            endcase
        end
    end
endmodule

// File: rtl/intc_top_chk.sv
module intc_top_chk #(
    parameter int N_IN = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic [2:0]      reg_addr,
    input logic            wr_en,
    input logic [31:0]     wdata,
    input logic            irq_out,
    input logic [N_IN-1:0] status_q,
    input logic [31:0]     enable_q,
    input logic [1:0]      master_q,
    input logic [N_IN-1:0] pending,
    input logic [31:0]     vec
);
    localparam logic [32:0] ONES_WIDE = (33'd1 << N_IN) - 33'd1;
    localparam logic [31:0] VALID     = ONES_WIDE[31:0];

    logic [31:0] pend32;
    assign pend32 = 32'(pending);

    p_irq_master_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> master_q == 2'b11);

    p_irq_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (status_q & enable_q[N_IN-1:0]) != '0);

    p_set_alias_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_addr == 3'd4) |=>
            ((enable_q & $past(wdata & VALID)) == $past(wdata & VALID)));

    p_clr_alias_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_addr == 3'd5) |=> ((enable_q & $past(wdata)) == 32'd0));

    p_enable_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_q & ~VALID) == 32'd0);

    p_vec_none_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pend32 == 32'd0) |-> (vec == 32'hFFFF_FFFF));

    p_vec_lowest_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pend32 != 32'd0) |-> (vec < N_IN
            && ((pend32 >> vec[4:0]) & 32'd1) == 32'd1
            && (pend32 & ((32'd1 << vec[4:0]) - 32'd1)) == 32'd0));
endmodule

bind intc_top intc_top_chk #(.N_IN(N_IN)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .reg_addr(reg_addr),
    .wr_en   (wr_en),
    .wdata   (wdata),
    .irq_out (irq_out),
    .status_q(status),
    .enable_q(enable),
    .master_q(master),
    .pending (pending),
    .vec     (vec_idx)
);

// File: tb/tb_intc_top.sv
module tb_intc_top;
    localparam int          N  = 8;
    localparam logic [31:0] KM = 32'h0000_FF0F;
    localparam logic [7:0]  KE = KM[7:0];

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [7:0]  irq_in = '0;
    logic        irq_out;

    int checks = 0, fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    intc_top #(.N_IN(N), .KIND_MASK(KM)) dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .wr_en(wr_en),
        .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .irq_in(irq_in),
        .irq_out(irq_out)
    );

    // Behavioural reference state
    logic [7:0] m_st = '0, m_en = '0, m_prev = '0;
    logic [1:0] m_me = '0;

    function automatic logic [31:0] m_vec();
        for (int i = 0; i < N; i++) if (m_st[i] & m_en[i]) return 32'(i);
        return 32'hFFFF_FFFF;
    endfunction

    function automatic logic [31:0] m_read(input logic [2:0] a);
        case (a)
            3'd0:    return {24'd0, m_st};
            3'd1:    return {24'd0, m_st & m_en};
            3'd2:    return {24'd0, m_en};
            3'd6:    return m_vec();
            3'd7:    return {30'd0, m_me};
            default: return 32'd0;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] a);
        case (a)
            3'd0, 3'd1, 3'd7: return "R7";
            3'd2:             return "R3";
            3'd6:             return "R8";
            default:          return "R9";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model, updated from the inputs sampled at each edge
    always @(posedge clk) begin
        logic [7:0] rise, setv, ackv;
        if (!rst_n) begin
            m_st = '0; m_en = '0; m_prev = '0; m_me = '0;
        end else begin
            rise = irq_in & ~m_prev;
            setv = (rise & KE) | (irq_in & ~KE);
            ackv = (wr_en && reg_addr == 3'd3) ? wdata[7:0] : 8'd0;
            m_st = (m_st & ~ackv) | setv;
            m_prev = irq_in;
            if (wr_en) begin
                case (reg_addr)
                    3'd2: m_en = wdata[7:0];
                    3'd4: m_en = m_en | wdata[7:0];
                    3'd5: m_en = m_en & ~wdata[7:0];
                    3'd7: m_me = wdata[1:0];
                    default: ;
                endcase
            end
        end
        #2;
        check("R2", {31'd0, irq_out}, {31'd0, (|(m_st & m_en)) & (&m_me)});
        if (rd_en) check(tag_of(reg_addr), rdata, m_read(reg_addr));
    end

    task automatic cyc(input logic w, input logic [2:0] a, input logic [31:0] d,
                       input logic [7:0] irq);
        @(negedge clk);
        wr_en = w; rd_en = 1'b0; reg_addr = a; wdata = d; irq_in = irq;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b1; reg_addr = a;
        #1;
        check(req, rdata, exp);
    endtask

    task automatic out_chk(input logic exp, input string req);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        #1;
        check(req, {31'd0, irq_out}, {31'd0, exp});
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd_chk(3'd0, 32'd0, "R1");
        rd_chk(3'd2, 32'd0, "R1");
        rd_chk(3'd7, 32'd0, "R1");
        rd_chk(3'd6, 32'hFFFF_FFFF, "R1");
        out_chk(1'b0, "R1");
        // Initialisation: enable off, acknowledge all, master on
        cyc(1, 3'd2, 32'd0, 8'h00);
        cyc(1, 3'd3, 32'hFFFF_FFFF, 8'h00);
        cyc(1, 3'd7, 32'd3, 8'h00);
        out_chk(1'b0, "R2");
        rd_chk(3'd7, 32'd3, "R7");
        // R11: edge on line 0 latched while disabled
        cyc(0, 3'd0, 32'd0, 8'h01);
        cyc(0, 3'd0, 32'd0, 8'h00);
        rd_chk(3'd0, 32'h01, "R11");
        rd_chk(3'd1, 32'h00, "R7");
        out_chk(1'b0, "R11");
        cyc(1, 3'd4, 32'h01, 8'h00);
        rd_chk(3'd1, 32'h01, "R11");
        rd_chk(3'd6, 32'd0, "R8");
        out_chk(1'b1, "R2");
        // R3/R10: set alias with bits above the line count
        cyc(1, 3'd4, 32'hFFFF_FF08, 8'h00);
        rd_chk(3'd2, 32'h09, "R10");
        // R2 partial master values
        cyc(1, 3'd7, 32'd1, 8'h00);
        out_chk(1'b0, "R2");
        cyc(1, 3'd7, 32'd2, 8'h00);
        out_chk(1'b0, "R2");
        cyc(1, 3'd7, 32'd3, 8'h00);
        out_chk(1'b1, "R2");
        // R5: acknowledge clears; line held high gives no new latch
        cyc(1, 3'd3, 32'h01, 8'h00);
        rd_chk(3'd0, 32'h00, "R5");
        cyc(0, 3'd0, 32'd0, 8'h01);
        cyc(1, 3'd3, 32'h01, 8'h01);
        cyc(0, 3'd0, 32'd0, 8'h01);
        rd_chk(3'd0, 32'h00, "R5");
        // R6: level line 5 re-latches while high
        cyc(1, 3'd4, 32'h20, 8'h20);
        cyc(1, 3'd3, 32'h20, 8'h20);
        rd_chk(3'd0, 32'h20, "R6");
        rd_chk(3'd6, 32'd5, "R8");
        cyc(0, 3'd0, 32'd0, 8'h00);
        cyc(1, 3'd3, 32'h20, 8'h00);
        rd_chk(3'd0, 32'h00, "R6");
        // R4: acknowledge and fresh edge on line 3 in one cycle
        cyc(0, 3'd0, 32'd0, 8'h08);
        cyc(0, 3'd0, 32'd0, 8'h00);
        cyc(1, 3'd3, 32'h08, 8'h08);
        rd_chk(3'd0, 32'h08, "R4");
        cyc(1, 3'd3, 32'h08, 8'h08);
        rd_chk(3'd0, 32'h00, "R5");
        // R3 clear alias and direct write; R10 out-of-range direct write
        cyc(1, 3'd5, 32'h21, 8'h00);
        rd_chk(3'd2, 32'h08, "R3");
        cyc(1, 3'd2, 32'h0000_0300, 8'h00);
        rd_chk(3'd2, 32'h00, "R10");
        cyc(1, 3'd2, 32'h81, 8'h00);
        rd_chk(3'd2, 32'h81, "R3");
        // R4 acknowledge all ones
        cyc(0, 3'd0, 32'd0, 8'h0F);
        cyc(0, 3'd0, 32'd0, 8'h00);
        rd_chk(3'd0, 32'h0F, "R5");
        cyc(1, 3'd3, 32'hFFFF_FFFF, 8'h00);
        rd_chk(3'd0, 32'h00, "R4");
        // R9 aliases read zero, read-only words ignore writes, rd_en gating
        rd_chk(3'd3, 32'd0, "R9");
        rd_chk(3'd4, 32'd0, "R9");
        rd_chk(3'd5, 32'd0, "R9");
        cyc(1, 3'd0, 32'hFF, 8'h00);
        cyc(1, 3'd6, 32'h3, 8'h00);
        rd_chk(3'd0, 32'h00, "R9");
        rd_chk(3'd6, 32'hFFFF_FFFF, "R9");
        cyc(0, 3'd2, 32'd0, 8'h00);
        #1;
        check("R9", rdata, 32'd0);
        // Random phase against the reference model
        for (int k = 0; k < 600; k++) begin
            @(negedge clk);
            wr_en = ($urandom_range(0, 9) < 3);
            rd_en = $urandom_range(0, 1);
            reg_addr = 3'($urandom_range(0, 7));
            wdata = $urandom;
            if ($urandom_range(0, 3) == 0) irq_in = 8'($urandom);
        end
        cyc(0, 3'd0, 32'd0, 8'h00);
        repeat (2) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule